// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the two low-order address bits for a four-beat memory burst. When an access begins, a load strobe captures a two-bit starting address; after that, each cycle in which the active-low advance input is low moves the output to the next beat. The other address bits, the storage array and the decision about when an access starts all belong to the surrounding logic.

A static strap input picks the beat order. With the strap low the order is linear: the start value plus the beat number, modulo four. With the strap high the order is interleaved: the start value XOR the beat number. A four-beat burst never leaves its aligned four-address block. After the fourth beat the sequence wraps and repeats.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset (active-low `rst_n`), `burst_addr` is 0.
- R2: On a clock edge with `load` high, `burst_addr` takes the value of `start_addr` at that edge and the beat count restarts at 0.
- R3: With `order_sel` = 0 (linear), each advance gives `burst_addr` = (start + beat) mod 4. Start 2 yields 2,3,0,1.
- R4: With `order_sel` = 1 (interleaved), each advance gives `burst_addr` = start XOR beat. Start 1 yields 1,0,3,2.
- R5: The sequence advances only on an edge where `adv_n` is 0. When `load` is 0 and `adv_n` is 1, `burst_addr` keeps its value.
- R6: When `load` and `adv_n` = 0 happen on the same edge, the load wins and the output equals the new start value.
- R7: After four advances the output returns to the start value, and the same four-beat sequence repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Start a burst by capturing start_addr |
| start_addr | input | 2 | First address of the burst |
| adv_n | input | 1 | Advance one beat when low |
| order_sel | input | 1 | Static strap: 0 linear, 1 interleaved |
| burst_addr | output | 2 | Current low address bits of the burst |

## Verification
Every result is registered, so the effect of a load, an advance or a hold appears on `burst_addr` one rising edge after the inputs that cause it. The bench drives inputs on the falling edge. It waits one full period after that edge and samples on the next falling edge, once the update edge has passed. A reference model in the bench keeps its own start value and beat count, and compares the output every cycle under random load, advance and hold mixes in both orders. Directed cases cover a load and an advance on the same edge, and wraparound after four beats.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic          adv_n,
  input  logic          order_sel,
  output logic [AW-1:0] burst_addr
);
  logic [AW-1:0] base_q, beat_q, beat_nx;

  assign beat_nx = beat_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= start_addr;
      beat_q <= '0;
    end else if (!adv_n) begin
      beat_q <= beat_nx;
    end
  end

  assign burst_addr = order_sel ? (base_q ^ beat_q) : (base_q + beat_q);
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic [AW-1:0] start_addr,
  input logic          adv_n,
  input logic          order_sel,
  input logic [AW-1:0] burst_addr
);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> burst_addr == $past(start_addr));
  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n && $stable(order_sel)) |=> $stable(burst_addr));
  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n && !order_sel) |=> (!order_sel -> burst_addr == AW'($past(burst_addr) + 1'b1)));
  // R4
  advance_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv_n && $stable(order_sel)) |=> burst_addr != $past(burst_addr));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
  .adv_n(adv_n), .order_sel(order_sel), .burst_addr(burst_addr)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, load = 0, adv_n = 1, order_sel = 1;
  logic [1:0] start_addr = 0;
  logic [1:0] burst_addr;
  int checks = 0, fails = 0;
  logic [1:0] m_base = 0, m_beat = 0;

  burst_addr_seq dut (.clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
    .adv_n(adv_n), .order_sel(order_sel), .burst_addr(burst_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] expect_addr(input logic [1:0] b, input logic [1:0] k, input logic o);
    return o ? (b ^ k) : 2'(b + k);
  endfunction

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (burst_addr !== exp) begin
      fails++;
      $display("FAIL %s: burst_addr=%0d expected=%0d", req, burst_addr, exp);
    end
  endtask

  task automatic step(input logic ld, input logic [1:0] sa, input logic an, input string req);
    load = ld; start_addr = sa; adv_n = an;
    @(posedge clk);
    if (ld) begin m_base = sa; m_beat = 0; end
    else if (!an) m_beat = m_beat + 1;
    @(negedge clk);
    check(req, expect_addr(m_base, m_beat, order_sel));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    @(negedge clk);
    check("R1", 2'd0);
    rst_n = 1;
    @(negedge clk);
    order_sel = 0;
    step(1, 2, 1, "R2");
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R3");
    check("R7", 2'd2);
    step(0, 0, 1, "R5");
    step(0, 0, 1, "R5");
    order_sel = 1;
    step(1, 1, 1, "R2");
    step(0, 0, 0, "R4");
    check("R4", 2'd0);
    step(0, 0, 0, "R4");
    check("R4", 2'd3);
    step(0, 0, 0, "R4");
    step(0, 0, 0, "R7");
    check("R7", 2'd1);
    step(1, 3, 0, "R6");
    check("R6", 2'd3);
    for (int m = 0; m < 2; m++) begin
      order_sel = m[0];
      step(1, 2'($urandom), 1, "R2");
      for (int i = 0; i < 300; i++) begin
        logic ld;
        ld = ($urandom % 8) == 0;
        step(ld, 2'($urandom), 1'($urandom), ld ? "R6" : (order_sel ? "R4" : "R3"));
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule